// File: doc/BRIEF.md
# Downward-Growing Stack Pointer Unit

This block holds the stack pointer of a small processor core and hands out the data-memory addresses for every stack access. Four operation strobes tell it what the core is doing:
- a single-byte push;
- a single-byte pop;
- a call or interrupt entry, which stores a two-byte return address;
- a return from a subroutine or an interrupt, which fetches a two-byte return address.

The stack grows toward lower addresses. A push writes at the pointer and then moves it down. A pop moves the pointer up and reads there. The pointer therefore always names the next free slot.

Software sees the pointer as two 8-bit registers in I/O space, one for the low byte and one for the high byte. The number of implemented pointer bits is a parameter. When that number is eight or less, the high-byte register does not exist. Bits above the implemented width read as zero, and writes to them are dropped.

The pointer resets to a parameterised top-of-RAM value. Before any call or interrupt, software is expected to load a value above 0x0100. The data memory is outside this block.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer equals TOP_OF_RAM. With the defaults (PTR_W=11, TOP_OF_RAM=0x04FF), `sp_o` reads 0x04FF, the low I/O byte reads 0xFF and the high I/O byte reads 0x04.
- R2: When `push_byte_i` is the only strobe, `addr_a_o` equals the current pointer in that cycle, `addr_b_o` is 0, and the pointer is one lower at the next clock.
- R3: When `pop_byte_i` is the only strobe, `addr_a_o` equals pointer+1 in that cycle, `addr_b_o` is 0, and the pointer is one higher at the next clock.
- R4: When `call_i` is the only strobe, `addr_a_o` equals the pointer and is the slot for the low byte of the return address. `addr_b_o` equals pointer-1 and is the slot for the high byte. The pointer is two lower at the next clock.
- R5: When `ret_i` is the only strobe, `addr_a_o` equals pointer+1 and is where the high byte is read. `addr_b_o` equals pointer+2 and is where the low byte is read. The pointer is two higher at the next clock.
- R6: When two or more strobes are high together, nothing is done: both addresses are 0 and the pointer keeps its value. When no strobe is high, both addresses are also 0.
- R7: `io_rdata_o` is combinational. It returns the pointer's bits 7:0 at address LO_ADDR (default 0x3D), bits 15:8 at HI_ADDR (default 0x3E), and 0x00 at any other address. Unimplemented bits read as zero.
- R8: With `io_we_i` high and no strobe, a write to LO_ADDR replaces bits 7:0 and a write to HI_ADDR replaces bits 15:8 at the next clock. Data bits at or above PTR_W are dropped. A write to any other address changes nothing.
- R9: When a stack strobe is high, an I/O write in the same cycle is discarded and the stack operation alone takes effect.
- R10: Pointer arithmetic and the addresses wrap modulo 2^PTR_W. For example, at PTR_W=11 a call at 0x0001 leaves the pointer at 0x07FF.
- R11: With PTR_W of 8 or less, the high-byte register does not exist: HI_ADDR reads 0x00 and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| push_byte_i | input | 1 | Single-byte push strobe |
| pop_byte_i | input | 1 | Single-byte pop strobe |
| call_i | input | 1 | Call or interrupt entry strobe (two-byte push) |
| ret_i | input | 1 | Subroutine or interrupt return strobe (two-byte pop) |
| io_we_i | input | 1 | I/O write enable |
| io_addr_i | input | IO_AW | I/O register address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data for io_addr_i |
| addr_a_o | output | 16 | First stack access address |
| addr_b_o | output | 16 | Second stack access address (two-byte operations only) |
| sp_o | output | 16 | Current pointer, zero-extended |

## Verification
On every cycle, the assertions check the pointer step for each lone strobe, taking wrap-around into account. They also check that colliding strobes leave the pointer unchanged, that the first access address follows the pointer, and that a lone write to the low byte lands.

The bench scenarios cover what a single-cycle property cannot show:
- the reset value;
- a call in the same cycle as an I/O write, and the write being dropped;
- masking of unimplemented high bits;
- a complete call and return round trip across the wrap point;
- the variant without a high-byte register, which the bench builds as a second instance with PTR_W=8.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef enum logic [2:0] {
      SP_OP_NONE  = 3'd0,
      SP_OP_PUSH1 = 3'd1,
      SP_OP_POP1  = 3'd2,
      SP_OP_PUSH2 = 3'd3,
      SP_OP_POP2  = 3'd4
   } sp_op_e;

   localparam int unsigned SP_FULL_W = 16;

   // Exactly one strobe selects an operation; none or several select nothing.
   function automatic sp_op_e sp_decode(input logic push1, input logic pop1,
                                        input logic push2, input logic pop2);
      sp_op_e op;
      op = SP_OP_NONE;
      unique case ({push1, pop1, push2, pop2})
         4'b1000: op = SP_OP_PUSH1;
         4'b0100: op = SP_OP_POP1;
         4'b0010: op = SP_OP_PUSH2;
         4'b0001: op = SP_OP_POP2;
         default: op = SP_OP_NONE;
      endcase
      return op;
   endfunction

endpackage

// File: rtl/sp_step_calc.sv
module sp_step_calc
   import sp_pkg::*;
#(
   parameter int unsigned PTR_W = 11
) (
   input  logic [PTR_W-1:0] sp_i,
   input  sp_op_e           op_i,
   output logic [PTR_W-1:0] sp_next_o,
   output logic             active_o
);

   localparam logic [PTR_W-1:0] STEP1 = PTR_W'(1);
   localparam logic [PTR_W-1:0] STEP2 = PTR_W'(2);

   always_comb begin
      sp_next_o = sp_i;
      active_o  = 1'b1;
      unique case (op_i)
         SP_OP_PUSH1: sp_next_o = sp_i - STEP1;
         SP_OP_POP1:  sp_next_o = sp_i + STEP1;
         SP_OP_PUSH2: sp_next_o = sp_i - STEP2;
         SP_OP_POP2:  sp_next_o = sp_i + STEP2;
         default:     active_o  = 1'b0;
      endcase
   end

endmodule

// File: rtl/sp_addr_gen.sv
module sp_addr_gen
   import sp_pkg::*;
#(
   parameter int unsigned PTR_W = 11
) (
   input  logic [PTR_W-1:0]     sp_i,
   input  sp_op_e               op_i,
   output logic [SP_FULL_W-1:0] addr_a_o,
   output logic [SP_FULL_W-1:0] addr_b_o
);

   localparam logic [PTR_W-1:0] STEP1 = PTR_W'(1);
   localparam logic [PTR_W-1:0] STEP2 = PTR_W'(2);

   logic [PTR_W-1:0] a_raw;
   logic [PTR_W-1:0] b_raw;

   always_comb begin
      a_raw = '0;
      b_raw = '0;
      unique case (op_i)
         SP_OP_PUSH1: a_raw = sp_i;
         SP_OP_POP1:  a_raw = sp_i + STEP1;
         SP_OP_PUSH2: begin
            a_raw = sp_i;           // low byte of return address
            b_raw = sp_i - STEP1;   // high byte of return address
         end
         SP_OP_POP2: begin
            a_raw = sp_i + STEP1;   // high byte read first
            b_raw = sp_i + STEP2;   // then low byte
         end
         default: begin
            a_raw = '0;
            b_raw = '0;
         end
      endcase
   end

   always_comb begin
      addr_a_o = '0;
      addr_b_o = '0;
      addr_a_o[PTR_W-1:0] = a_raw;
      addr_b_o[PTR_W-1:0] = b_raw;
   end

endmodule

// File: rtl/sp_io_port.sv
module sp_io_port
   import sp_pkg::*;
#(
   parameter int unsigned PTR_W   = 11,
   parameter int unsigned IO_AW   = 6,
   parameter logic [IO_AW-1:0] LO_ADDR = IO_AW'(6'h3D),
   parameter logic [IO_AW-1:0] HI_ADDR = IO_AW'(6'h3E)
) (
   input  logic [PTR_W-1:0] sp_i,
   input  logic             io_we_i,
   input  logic [IO_AW-1:0] io_addr_i,
   input  logic [7:0]       io_wdata_i,
   output logic [7:0]       io_rdata_o,
   output logic             wr_hit_o,
   output logic [PTR_W-1:0] wr_value_o
);

   localparam bit HAS_HI = (PTR_W > 8);

   logic [SP_FULL_W-1:0] sp_ext;
   logic [SP_FULL_W-1:0] merged;
   logic                 lo_sel;
   logic                 hi_sel;
   logic [7:0]           hi_rd;

   always_comb begin
      sp_ext = '0;
      sp_ext[PTR_W-1:0] = sp_i;
   end

   assign lo_sel = (io_addr_i == LO_ADDR);

   generate
      if (HAS_HI) begin : g_hi_present
         assign hi_sel = (io_addr_i == HI_ADDR);
         assign hi_rd  = sp_ext[15:8];
      end else begin : g_hi_absent
         assign hi_sel = 1'b0;
         assign hi_rd  = 8'h00;
      end
   endgenerate

   always_comb begin
      if (lo_sel)
         io_rdata_o = sp_ext[7:0];
      else if (io_addr_i == HI_ADDR)
         io_rdata_o = hi_rd;
      else
         io_rdata_o = 8'h00;
   end

   assign wr_hit_o = io_we_i && (lo_sel || hi_sel);

   always_comb begin
      merged = sp_ext;
      if (lo_sel) merged[7:0]  = io_wdata_i;
      if (hi_sel) merged[15:8] = io_wdata_i;
      wr_value_o = merged[PTR_W-1:0];
   end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
   import sp_pkg::*;
#(
   parameter int unsigned PTR_W      = 11,
   parameter int unsigned IO_AW      = 6,
   parameter logic [15:0] TOP_OF_RAM = 16'h04FF,
   parameter logic [IO_AW-1:0] LO_ADDR = IO_AW'(6'h3D),
   parameter logic [IO_AW-1:0] HI_ADDR = IO_AW'(6'h3E)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_byte_i,
   input  logic             pop_byte_i,
   input  logic             call_i,
   input  logic             ret_i,
   input  logic             io_we_i,
   input  logic [IO_AW-1:0] io_addr_i,
   input  logic [7:0]       io_wdata_i,
   output logic [7:0]       io_rdata_o,
   output logic [15:0]      addr_a_o,
   output logic [15:0]      addr_b_o,
   output logic [15:0]      sp_o
);

   localparam logic [PTR_W-1:0] RESET_SP = TOP_OF_RAM[PTR_W-1:0];

   generate
      if (PTR_W < 2 || PTR_W > 16) begin : g_bad_ptr_w
         $error("stack_ptr_unit: PTR_W must lie in 2..16");
      end
      if (IO_AW < 1) begin : g_bad_io_aw
         $error("stack_ptr_unit: IO_AW must be at least 1");
      end
      if (LO_ADDR == HI_ADDR) begin : g_bad_map
         $error("stack_ptr_unit: LO_ADDR and HI_ADDR must differ");
      end
   endgenerate

   sp_op_e           op;
   logic [PTR_W-1:0] sp_q;
   logic [PTR_W-1:0] sp_step;
   logic             step_active;
   logic             wr_hit;
   logic [PTR_W-1:0] wr_value;

   assign op = sp_decode(push_byte_i, pop_byte_i, call_i, ret_i);

   sp_step_calc #(.PTR_W(PTR_W)) u_step (
      .sp_i      (sp_q),
      .op_i      (op),
      .sp_next_o (sp_step),
      .active_o  (step_active)
   );

   sp_addr_gen #(.PTR_W(PTR_W)) u_addr (
      .sp_i     (sp_q),
      .op_i     (op),
      .addr_a_o (addr_a_o),
      .addr_b_o (addr_b_o)
   );

   sp_io_port #(
      .PTR_W   (PTR_W),
      .IO_AW   (IO_AW),
      .LO_ADDR (LO_ADDR),
      .HI_ADDR (HI_ADDR)
   ) u_io (
      .sp_i       (sp_q),
      .io_we_i    (io_we_i),
      .io_addr_i  (io_addr_i),
      .io_wdata_i (io_wdata_i),
      .io_rdata_o (io_rdata_o),
      .wr_hit_o   (wr_hit),
      .wr_value_o (wr_value)
   );

   // Any strobe, valid or colliding, blocks the I/O write (R9).
   logic any_strobe;
   assign any_strobe = push_byte_i | pop_byte_i | call_i | ret_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= RESET_SP;
      else if (step_active)
         sp_q <= sp_step;
      else if (wr_hit && !any_strobe)
         sp_q <= wr_value;
   end

   always_comb begin
      sp_o = '0;
      sp_o[PTR_W-1:0] = sp_q;
   end

endmodule

// File: rtl/sp_unit_chk.sv
module sp_unit_chk #(
   parameter int unsigned PTR_W = 11,
   parameter int unsigned IO_AW = 6,
   parameter logic [IO_AW-1:0] LO_ADDR = IO_AW'(6'h3D)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             push_byte_i,
   input logic             pop_byte_i,
   input logic             call_i,
   input logic             ret_i,
   input logic             io_we_i,
   input logic [IO_AW-1:0] io_addr_i,
   input logic [7:0]       io_wdata_i,
   input logic [15:0]      addr_a_o,
   input logic [15:0]      sp_o
);

   localparam logic [15:0] MASK = (PTR_W >= 16) ? 16'hFFFF : 16'((32'd1 << PTR_W) - 32'd1);

   logic [3:0] strobes;
   assign strobes = {push_byte_i, pop_byte_i, call_i, ret_i};

   // R2
   p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes == 4'b1000) |=> (sp_o == (($past(sp_o) - 16'd1) & MASK)));

   // R3
   p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes == 4'b0100) |=> (sp_o == (($past(sp_o) + 16'd1) & MASK)));

   // R4
   p_call_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes == 4'b0010) |=> (sp_o == (($past(sp_o) - 16'd2) & MASK)));

   // R5
   p_ret_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes == 4'b0001) |=> (sp_o == (($past(sp_o) + 16'd2) & MASK)));

   // R6
   p_collide_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(strobes) > 1) |=> $stable(sp_o));

   // R2, R4: the write slot follows the pointer
   p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes == 4'b1000 || strobes == 4'b0010) |-> (addr_a_o == sp_o));

   generate
      if (PTR_W >= 8) begin : g_lo_wr
         // R8
         p_lo_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (strobes == 4'b0000 && io_we_i && io_addr_i == LO_ADDR)
            |=> (sp_o[7:0] == $past(io_wdata_i)));
      end
   endgenerate

endmodule

bind stack_ptr_unit sp_unit_chk #(
   .PTR_W   (PTR_W),
   .IO_AW   (IO_AW),
   .LO_ADDR (LO_ADDR)
) u_sp_unit_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .push_byte_i (push_byte_i),
   .pop_byte_i  (pop_byte_i),
   .call_i      (call_i),
   .ret_i       (ret_i),
   .io_we_i     (io_we_i),
   .io_addr_i   (io_addr_i),
   .io_wdata_i  (io_wdata_i),
   .addr_a_o    (addr_a_o),
   .sp_o        (sp_o)
);

// File: tb/stack_ptr_unit_bench.sv
`timescale 1ns/1ps
module stack_ptr_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_b, pop_b, call_s, ret_s, we;
   logic [5:0]  addr;
   logic [7:0]  wdata;
   logic [7:0]  rdata;
   logic [15:0] a_o, b_o, sp;

   // second instance: 8-bit pointer, no high byte register (R11)
   logic        s_push, s_we;
   logic [5:0]  s_addr;
   logic [7:0]  s_wdata, s_rdata;
   logic [15:0] s_a, s_b, s_sp;

   int unsigned n_checks = 0;
   int unsigned n_fail   = 0;
   bit          done     = 1'b0;

   always #2.5 clk = ~clk;

   stack_ptr_unit u_stack_ptr_unit (
      .clk (clk), .rst_n (rst_n),
      .push_byte_i (push_b), .pop_byte_i (pop_b), .call_i (call_s), .ret_i (ret_s),
      .io_we_i (we), .io_addr_i (addr), .io_wdata_i (wdata), .io_rdata_o (rdata),
      .addr_a_o (a_o), .addr_b_o (b_o), .sp_o (sp)
   );

   stack_ptr_unit #(.PTR_W(8), .TOP_OF_RAM(16'h00F0)) u_stack_ptr_unit_small (
      .clk (clk), .rst_n (rst_n),
      .push_byte_i (s_push), .pop_byte_i (1'b0), .call_i (1'b0), .ret_i (1'b0),
      .io_we_i (s_we), .io_addr_i (s_addr), .io_wdata_i (s_wdata), .io_rdata_o (s_rdata),
      .addr_a_o (s_a), .addr_b_o (s_b), .sp_o (s_sp)
   );

   // {push,pop,call,ret, we, addr[5:0], wdata[7:0], exp_a, exp_b, exp_sp}
   localparam int NV = 17;
   localparam logic [66:0] VEC [NV] = '{
      {4'b1000, 1'b0, 6'h00, 8'h00, 16'h04FF, 16'h0000, 16'h04FE}, // R2
      {4'b1000, 1'b0, 6'h00, 8'h00, 16'h04FE, 16'h0000, 16'h04FD}, // R2
      {4'b0100, 1'b0, 6'h00, 8'h00, 16'h04FE, 16'h0000, 16'h04FE}, // R3
      {4'b0010, 1'b0, 6'h00, 8'h00, 16'h04FE, 16'h04FD, 16'h04FC}, // R4
      {4'b0001, 1'b0, 6'h00, 8'h00, 16'h04FD, 16'h04FE, 16'h04FE}, // R5
      {4'b1100, 1'b0, 6'h00, 8'h00, 16'h0000, 16'h0000, 16'h04FE}, // R6
      {4'b0000, 1'b1, 6'h3D, 8'h10, 16'h0000, 16'h0000, 16'h0410}, // R8
      {4'b0000, 1'b1, 6'h3E, 8'hFF, 16'h0000, 16'h0000, 16'h0710}, // R8 masked
      {4'b0010, 1'b1, 6'h3D, 8'h55, 16'h0710, 16'h070F, 16'h070E}, // R9
      {4'b0000, 1'b1, 6'h20, 8'h00, 16'h0000, 16'h0000, 16'h070E}, // R8 other addr
      {4'b0000, 1'b1, 6'h3E, 8'h00, 16'h0000, 16'h0000, 16'h000E}, // R8
      {4'b0001, 1'b0, 6'h00, 8'h00, 16'h000F, 16'h0010, 16'h0010}, // R5
      {4'b0000, 1'b1, 6'h3D, 8'h01, 16'h0000, 16'h0000, 16'h0001}, // R8
      {4'b0010, 1'b0, 6'h00, 8'h00, 16'h0001, 16'h0000, 16'h07FF}, // R10
      {4'b0100, 1'b0, 6'h00, 8'h00, 16'h0000, 16'h0000, 16'h0000}, // R10
      {4'b1000, 1'b0, 6'h00, 8'h00, 16'h0000, 16'h0000, 16'h07FF}, // R10
      {4'b0001, 1'b0, 6'h00, 8'h00, 16'h0000, 16'h0001, 16'h0001}  // R10
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic idle();
      {push_b, pop_b, call_s, ret_s, we} = '0;
      addr = '0; wdata = '0;
      s_push = 1'b0; s_we = 1'b0; s_addr = '0; s_wdata = '0;
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 sp", sp, 16'h04FF);
      addr = 6'h3D; #1 chk("R1 lo byte", {8'h00, rdata}, 16'h00FF);
      addr = 6'h3E; #1 chk("R1 hi byte", {8'h00, rdata}, 16'h0004);
      chk("R1 small sp", s_sp, 16'h00F0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {push_b, pop_b, call_s, ret_s} = VEC[i][66:63];
         we    = VEC[i][62];
         addr  = VEC[i][61:56];
         wdata = VEC[i][55:48];
         #1;
         chk($sformatf("vec%0d addr_a (R2-R6 path)", i), a_o, VEC[i][47:32]);
         chk($sformatf("vec%0d addr_b R4/R5", i), b_o, VEC[i][31:16]);
         @(posedge clk); #1;
         chk($sformatf("vec%0d pointer R2/R3/R4/R5/R6/R8/R9/R10", i), sp, VEC[i][15:0]);
         idle();
      end

      // R7 read map, pointer is 0x0001
      @(negedge clk);
      addr = 6'h3D; #1 chk("R7 lo read", {8'h00, rdata}, 16'h0001);
      addr = 6'h3E; #1 chk("R7 hi read", {8'h00, rdata}, 16'h0000);
      addr = 6'h21; #1 chk("R7 other read", {8'h00, rdata}, 16'h0000);
      chk("R6 idle addr_a", a_o, 16'h0000);

      // R11 small variant: high byte absent
      s_we = 1'b1; s_addr = 6'h3E; s_wdata = 8'h12;
      @(posedge clk); #1;
      chk("R11 hi write ignored", s_sp, 16'h00F0);
      s_we = 1'b0; #1 chk("R11 hi reads zero", {8'h00, s_rdata}, 16'h0000);
      s_addr = 6'h3D; #1 chk("R11 lo read", {8'h00, s_rdata}, 16'h00F0);
      @(negedge clk);
      s_push = 1'b1; #1 chk("R11 push addr", s_a, 16'h00F0);
      @(posedge clk); #1 chk("R11 push step", s_sp, 16'h00EF);
      idle();

      // R1 reset again mid-run
      @(negedge clk); rst_n = 1'b0;
      #1 chk("R1 async reset", sp, 16'h04FF);
      @(negedge clk); rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

endmodule